// File: doc/BRIEF.md
# Lockstep Multi-Converter Serial Sequencer

This block is the host side of a small array of identical delta-sigma converters that share one serial clock line and one host-to-converter data line, with a separate active-low select and a separate return data line for each converter. After reset it sends the converter reset sequence and then the start-conversion command with every select driven low in the same cycle. Every converter therefore starts from the same clock edge and their conversions stay aligned. From then on it watches only converter 0 for a ready indication, and it drains the converters one after another. Each read clears the ready flag with a dummy byte and then shifts in a 32-bit result word.

Each result leaves the block on a valid/ready handshake. The payload carries the channel index, the 24-bit sample (the top three bytes of the word), the overflow flag taken from the low byte, and the coding mode that applied to the read. The sample is passed on unaltered: straight binary from 000000h to FFFFFFh when the mode input is low, two's complement from 800000h to 7FFFFFh when it is high. A timer starts at each ready detection. If the array has not been fully drained when that timer expires, the block raises a sticky overrun flag.

The sequencer states are BOOT, RST_GO, RST_RUN, PAUSE, CMD_GO, CMD_RUN, HUNT, CLR_GO, CLR_RUN, RD_GO, RD_RUN, EMIT and NEXT. The transitions are:
- BOOT→RST_GO.
- RST_GO→RST_RUN.
- RST_RUN→RST_GO while reset bytes remain, otherwise RST_RUN→PAUSE.
- PAUSE→CMD_GO→CMD_RUN.
- CMD_RUN→HUNT when the command byte is done.
- HUNT→CLR_GO when converter 0's data line is low.
- CLR_GO→CLR_RUN→RD_GO→RD_RUN→EMIT.
- EMIT→NEXT→CLR_GO when the result is accepted and more channels remain.
- EMIT→HUNT when the result is accepted and the last channel has been read.

Top module: `adc_lockstep_ctrl`

## Requirements
- R1: While reset is held, every select is high, the serial clock is low, res_valid_o is low and overrun_o is low.
- R2: After reset, every select is driven low together and RST_BYTES bytes go out MSB first: RST_FILL repeated RST_BYTES-1 times, then RST_LAST. Every converter sees the identical bit stream.
- R3: After the reset bytes and a pause with all selects high, the START_CMD byte is sent MSB first, again with every select low together.
- R4: The data line to the converters changes only while the serial clock is low, so it is stable at each rising edge. The serial clock stays low whenever no select is asserted.
- R5: While waiting for a result, only select 0 is low and no serial clock is produced. A read begins only after converter 0's data line is seen low.
- R6: Each channel read is 8 dummy clocks followed by 32 clocks, with the data line to the converters held low throughout. The result is sampled on rising edges, MSB first, and res_sample_o is bits 31..8 of the word.
- R7: res_ovf_o equals bit OVF_BIT (default 3) of the result word's low byte. The other low-byte bits have no effect on the outputs.
- R8: Within one ready event, channels are read in order 0 to N_CONV-1, with res_chan_o giving the index. Only one select is low during a read.
- R9: While res_valid_o is high and res_ready_i is low, res_valid_o stays high and the payload stays unchanged.
- R10: res_mode_o reports the bipolar_i level at the end of that channel's read. The sample bits are passed unchanged in either mode.
- R11: If CONV_CYCLES clocks pass after a ready detection and the block has not yet returned to waiting, overrun_o goes high and stays high until reset. A drain that finishes in time leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_o | output | 1 | Shared serial clock |
| mosi_o | output | 1 | Shared host-to-converter data |
| cs_n_o | output | N_CONV | Per-converter active-low select |
| miso_i | input | N_CONV | Per-converter return data |
| bipolar_i | input | 1 | Coding mode in force: 1 two's complement, 0 straight binary |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts result |
| res_chan_o | output | CHW | Channel index of the result |
| res_sample_o | output | 24 | Conversion sample |
| res_ovf_o | output | 1 | Overflow flag of the conversion |
| res_mode_o | output | 1 | Coding mode captured with the result |
| overrun_o | output | 1 | Sticky: the drain was late |

## Verification
The hardest condition to reach is the overrun. It needs a consumer that stalls longer than a whole conversion period while the sequencer sits mid-array. Fast consumers must never trip it. The bench uses behavioural converter models that all report ready at once. Over many rounds it applies short back-pressure on a rotating channel, which stays well under the limit. In a final round it holds res_ready_i low on channel 0 past CONV_CYCLES, then drains the rest of the array. The rounds also sweep the corner codes 000000h, FFFFFFh, 800000h and 7FFFFFh, a walking one, and the overflow bit with scrambled neighbouring bits, under both coding modes.

// File: rtl/lk_pkg.sv
package lk_pkg;
    localparam int FRAME_BITS  = 32;
    localparam int SAMPLE_BITS = 24;
    localparam int BYTE_BITS   = 8;

    typedef enum logic [3:0] {
        S_BOOT,
        S_RST_GO,
        S_RST_RUN,
        S_PAUSE,
        S_CMD_GO,
        S_CMD_RUN,
        S_HUNT,
        S_CLR_GO,
        S_CLR_RUN,
        S_RD_GO,
        S_RD_RUN,
        S_EMIT,
        S_NEXT
    } seq_state_t;
endpackage

// File: rtl/lk_shift_engine.sv
module lk_shift_engine #(
    parameter int HALF_DIV = 2,
    parameter int WW       = 32,
    localparam int DW      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1,
    localparam int CW      = $clog2(WW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] nbits_i,
    input  logic [WW-1:0] tx_i,
    input  logic          miso_i,
    output logic          sclk_o,
    output logic          mosi_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [WW-1:0] rx_o
);
    logic [DW-1:0] div_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] nb_q;
    logic [WW-1:0] tx_sh_q;
    logic [WW-1:0] rx_sh_q;
    logic          sclk_q;
    logic          mosi_q;
    logic          busy_q;
    logic          done_q;
    logic          tick;

    assign tick = (div_q == DW'(HALF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            cnt_q   <= '0;
            nb_q    <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            sclk_q  <= 1'b0;
            mosi_q  <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !busy_q) begin
                busy_q  <= 1'b1;
                tx_sh_q <= tx_i;
                mosi_q  <= tx_i[WW-1];
                sclk_q  <= 1'b0;
                div_q   <= '0;
                cnt_q   <= '0;
                nb_q    <= nbits_i;
            end else if (busy_q) begin
                if (tick) begin
                    div_q <= '0;
                    if (!sclk_q) begin
                        sclk_q  <= 1'b1;
                        rx_sh_q <= {rx_sh_q[WW-2:0], miso_i};
                    end else begin
                        sclk_q <= 1'b0;
                        if ((cnt_q + CW'(1)) == nb_q) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                            mosi_q <= 1'b0;
                        end else begin
                            cnt_q   <= cnt_q + CW'(1);
                            tx_sh_q <= {tx_sh_q[WW-2:0], 1'b0};
                            mosi_q  <= tx_sh_q[WW-2];
                        end
                    end
                end else begin
                    div_q <= div_q + DW'(1);
                end
            end
        end
    end

    assign sclk_o = sclk_q;
    assign mosi_o = mosi_q;
    assign busy_o = busy_q;
    assign done_o = done_q;
    assign rx_o   = rx_sh_q;

    // R4: the data line holds still across every rising serial clock edge
    assert_mosi_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> $stable(mosi_q));
    // R4: no serial clock high once the engine has gone idle
    assert_idle_clock_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |=> !sclk_q || busy_q);
endmodule

// File: rtl/lk_period_watch.sv
module lk_period_watch #(
    parameter int LIMIT = 20000,
    localparam int TW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rearm_i,
    input  logic home_i,
    output logic overrun_o
);
    logic [TW-1:0] tmr_q;
    logic          armed_q;
    logic          ovr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q   <= '0;
            armed_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (rearm_i) begin
            tmr_q   <= '0;
            armed_q <= 1'b1;
        end else if (armed_q) begin
            if (home_i) begin
                armed_q <= 1'b0;
            end else if (tmr_q == TW'(LIMIT - 1)) begin
                armed_q <= 1'b0;
                ovr_q   <= 1'b1;
            end else begin
                tmr_q <= tmr_q + TW'(1);
            end
        end
    end

    assign overrun_o = ovr_q;

    // R11: the overrun flag never clears on its own
    assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> ovr_q);
    // R11: an overrun only appears while a drain is in progress
    assert_overrun_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(armed_q));
endmodule

// File: rtl/adc_lockstep_ctrl.sv
module adc_lockstep_ctrl
    import lk_pkg::*;
#(
    parameter int         N_CONV      = 4,
    parameter int         HALF_DIV    = 2,
    parameter int         RST_BYTES   = 4,
    parameter logic [7:0] RST_FILL    = 8'hFF,
    parameter logic [7:0] RST_LAST    = 8'hFE,
    parameter logic [7:0] START_CMD   = 8'hC0,
    parameter int         OVF_BIT     = 3,
    parameter int         CONV_CYCLES = 20000,
    localparam int        CHW         = (N_CONV > 1) ? $clog2(N_CONV) : 1,
    localparam int        RBW         = $clog2(RST_BYTES + 1),
    localparam int        NBW         = $clog2(FRAME_BITS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic                   sclk_o,
    output logic                   mosi_o,
    output logic [N_CONV-1:0]      cs_n_o,
    input  logic [N_CONV-1:0]      miso_i,
    input  logic                   bipolar_i,
    output logic                   res_valid_o,
    input  logic                   res_ready_i,
    output logic [CHW-1:0]         res_chan_o,
    output logic [SAMPLE_BITS-1:0] res_sample_o,
    output logic                   res_ovf_o,
    output logic                   res_mode_o,
    output logic                   overrun_o
);
    localparam logic [N_CONV-1:0] ALL_SEL = '0;
    localparam logic [N_CONV-1:0] NO_SEL  = '1;

    seq_state_t state_q, state_d;

    logic [CHW-1:0]        ch_q;
    logic [RBW-1:0]        rbyte_q;
    logic                  last_rbyte;
    logic                  last_ch;
    logic                  eng_start;
    logic [NBW-1:0]        eng_nbits;
    logic [FRAME_BITS-1:0] eng_tx;
    logic                  eng_busy;
    logic                  eng_done;
    logic [FRAME_BITS-1:0] eng_rx;
    logic                  miso_sel;
    logic                  rdy_seen;
    logic [N_CONV-1:0]     cs_n_d;
    logic [N_CONV-1:0]     one_sel;

    logic [CHW-1:0]         chan_q;
    logic [SAMPLE_BITS-1:0] sample_q;
    logic                   ovf_q;
    logic                   mode_q;

    assign last_rbyte = (rbyte_q == RBW'(RST_BYTES - 1));
    assign last_ch    = (ch_q == CHW'(N_CONV - 1));
    assign miso_sel   = miso_i[ch_q];
    assign one_sel    = ~(N_CONV'(1) << ch_q);

    lk_shift_engine #(
        .HALF_DIV (HALF_DIV),
        .WW       (FRAME_BITS)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (eng_start),
        .nbits_i (eng_nbits),
        .tx_i    (eng_tx),
        .miso_i  (miso_sel),
        .sclk_o  (sclk_o),
        .mosi_o  (mosi_o),
        .busy_o  (eng_busy),
        .done_o  (eng_done),
        .rx_o    (eng_rx)
    );

    lk_period_watch #(
        .LIMIT (CONV_CYCLES)
    ) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .rearm_i   (rdy_seen),
        .home_i    (state_q == S_HUNT),
        .overrun_o (overrun_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_BOOT;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        eng_start = 1'b0;
        eng_nbits = NBW'(BYTE_BITS);
        eng_tx    = '0;
        cs_n_d    = NO_SEL;
        rdy_seen  = 1'b0;
        unique case (state_q)
            S_BOOT: state_d = S_RST_GO;
            S_RST_GO: begin
                cs_n_d    = ALL_SEL;
                eng_start = 1'b1;
                eng_tx    = {(last_rbyte ? RST_LAST : RST_FILL), {(FRAME_BITS-BYTE_BITS){1'b0}}};
                state_d   = S_RST_RUN;
            end
            S_RST_RUN: begin
                cs_n_d = ALL_SEL;
                if (eng_done) state_d = last_rbyte ? S_PAUSE : S_RST_GO;
            end
            S_PAUSE: state_d = S_CMD_GO;
            S_CMD_GO: begin
                cs_n_d    = ALL_SEL;
                eng_start = 1'b1;
                eng_tx    = {START_CMD, {(FRAME_BITS-BYTE_BITS){1'b0}}};
                state_d   = S_CMD_RUN;
            end
            S_CMD_RUN: begin
                cs_n_d = ALL_SEL;
                if (eng_done) state_d = S_HUNT;
            end
            S_HUNT: begin
                cs_n_d = one_sel;
                if (!miso_sel) begin
                    rdy_seen = 1'b1;
                    state_d  = S_CLR_GO;
                end
            end
            S_CLR_GO: begin
                cs_n_d    = one_sel;
                eng_start = 1'b1;
                state_d   = S_CLR_RUN;
            end
            S_CLR_RUN: begin
                cs_n_d = one_sel;
                if (eng_done) state_d = S_RD_GO;
            end
            S_RD_GO: begin
                cs_n_d    = one_sel;
                eng_start = 1'b1;
                eng_nbits = NBW'(FRAME_BITS);
                state_d   = S_RD_RUN;
            end
            S_RD_RUN: begin
                cs_n_d = one_sel;
                if (eng_done) state_d = S_EMIT;
            end
            S_EMIT: begin
                if (res_ready_i) state_d = last_ch ? S_HUNT : S_NEXT;
            end
            S_NEXT: state_d = S_CLR_GO;
            default: state_d = S_BOOT;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q     <= '0;
            rbyte_q  <= '0;
            chan_q   <= '0;
            sample_q <= '0;
            ovf_q    <= 1'b0;
            mode_q   <= 1'b0;
        end else begin
            if (state_q == S_RST_RUN && eng_done && !last_rbyte)
                rbyte_q <= rbyte_q + RBW'(1);
            if (state_q == S_RD_RUN && eng_done) begin
                chan_q   <= ch_q;
                sample_q <= eng_rx[FRAME_BITS-1:BYTE_BITS];
                ovf_q    <= eng_rx[OVF_BIT];
                mode_q   <= bipolar_i;
            end
            if (state_q == S_EMIT && res_ready_i)
                ch_q <= last_ch ? '0 : ch_q + CHW'(1);
        end
    end

    assign cs_n_o       = cs_n_d;
    assign res_valid_o  = (state_q == S_EMIT);
    assign res_chan_o   = chan_q;
    assign res_sample_o = sample_q;
    assign res_ovf_o    = ovf_q;
    assign res_mode_o   = mode_q;

    // R4: clock is quiet while nothing is selected
    assert_sclk_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n_o) |-> !sclk_o);
    // R8: selects are either all low (broadcast) or at most one low
    assert_select_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o == ALL_SEL) || $onehot0(~cs_n_o));
    // R8: channel index stays inside the array
    assert_chan_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (res_chan_o <= CHW'(N_CONV - 1)));
    // R9: held result does not move under back-pressure
    assert_hold_payload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_ready_i) |=> res_valid_o &&
            $stable({res_chan_o, res_sample_o, res_ovf_o, res_mode_o}));
    // R5: a read never begins unless the shifter was idle
    assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !eng_busy);
endmodule

// File: tb/tb_adc_lockstep_ctrl.sv
module tb_adc_lockstep_ctrl;
    localparam int N     = 3;
    localparam int HALF  = 2;
    localparam int RB    = 3;
    localparam int LIM   = 1200;
    localparam int NR    = 16;
    localparam logic [31:0] CMD_STREAM = 32'hFFFF_FE80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk, mosi;
    logic [N-1:0] cs_n;
    logic [N-1:0] miso;
    logic bipolar = 1'b0;
    logic res_valid;
    logic res_ready = 1'b0;
    logic [1:0] res_chan;
    logic [23:0] res_sample;
    logic res_ovf, res_mode, overrun;

    int total = 0;
    int bad = 0;
    int arm_round = 0;
    int served [N];
    int fcnt [N];
    int cmd_cnt [N];
    logic [31:0] cmd_bits [N];
    int edge_bad = 0;
    int quiet_bad = 0;
    int mosi_rd_bad = 0;
    logic mosi_prev = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_lockstep_ctrl #(
        .N_CONV(N), .HALF_DIV(HALF), .RST_BYTES(RB),
        .RST_FILL(8'hFF), .RST_LAST(8'hFE), .START_CMD(8'h80),
        .OVF_BIT(3), .CONV_CYCLES(LIM)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sclk_o(sclk), .mosi_o(mosi), .cs_n_o(cs_n),
        .miso_i(miso), .bipolar_i(bipolar), .res_valid_o(res_valid),
        .res_ready_i(res_ready), .res_chan_o(res_chan), .res_sample_o(res_sample),
        .res_ovf_o(res_ovf), .res_mode_o(res_mode), .overrun_o(overrun)
    );

    function automatic logic [31:0] mk_word(int r, int c);
        logic [23:0] s;
        logic [7:0]  lo;
        case (r)
            0: s = 24'h000000;
            1: s = 24'hFFFFFF;
            2: s = 24'h800000;
            3: s = 24'h7FFFFF;
            4: s = 24'h000001;
            5: s = 24'hFFFFFE;
            default: s = (24'h1 << ((r * 3 + c) % 24)) ^ 24'(r * 32'h010203 + c * 32'h000A0B);
        endcase
        lo = 8'((r * 5 + c * 3) & 8'hF7);
        if (((r + c) & 1) == 1) lo[3] = 1'b1;
        return {s, lo};
    endfunction

    // behavioural converters
    for (genvar g = 0; g < N; g++) begin : g_adc
        logic rdy;
        logic [31:0] w;
        assign rdy = (served[g] < arm_round);
        assign w = mk_word(arm_round - 1, g);
        assign miso[g] = (cs_n[g] || !rdy) ? 1'b1 :
                         (fcnt[g] < 8) ? 1'b0 : w[39 - fcnt[g]];
        initial begin
            served[g] = 0; fcnt[g] = 0; cmd_cnt[g] = 0; cmd_bits[g] = '0;
        end
        always @(negedge sclk) begin
            if (!cs_n[g] && rdy) begin
                if (fcnt[g] == 39) begin
                    fcnt[g] = 0;
                    served[g] = served[g] + 1;
                end else begin
                    fcnt[g] = fcnt[g] + 1;
                end
            end
        end
        always @(posedge sclk) begin
            if (!cs_n[g] && !rdy) begin
                cmd_bits[g] = {cmd_bits[g][30:0], mosi};
                cmd_cnt[g] = cmd_cnt[g] + 1;
            end
            if (!cs_n[g] && rdy && mosi) mosi_rd_bad = mosi_rd_bad + 1;
        end
    end

    // edge discipline monitor (R4)
    always @(negedge clk) begin
        if (rst_n) begin
            if (mosi != mosi_prev && sclk) edge_bad = edge_bad + 1;
            if ((&cs_n) && sclk) edge_bad = edge_bad + 1;
        end
        mosi_prev = mosi;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_valid();
        while (!res_valid) @(negedge clk);
    endtask

    task automatic accept();
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cs_n == '1 && !sclk && !res_valid && !overrun, "R1 reset outputs",
            {cs_n, sclk, res_valid, overrun}, {3'b111, 3'b000});
        rst_n = 1'b1;
        while (cs_n != 3'b110) @(negedge clk);
        // R2 R3: broadcast reset bytes then start command, identical on every converter
        for (int c = 0; c < N; c++) begin
            chk(cmd_cnt[c] == 32, "R2 broadcast bit count", cmd_cnt[c], 32);
            chk(cmd_bits[c] == CMD_STREAM, "R3 reset bytes and start command", cmd_bits[c], CMD_STREAM);
        end
        // R5: idle waiting window, no ready from converter 0
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (cs_n != 3'b110 || sclk || res_valid) quiet_bad = quiet_bad + 1;
        end
        chk(quiet_bad == 0, "R5 waiting holds only select 0 with clock quiet", quiet_bad, 0);

        for (int r = 0; r < NR; r++) begin
            bipolar = r[0];
            arm_round = r + 1;
            for (int c = 0; c < N; c++) begin
                logic [31:0] w;
                logic [31:0] snap;
                int stall;
                w = mk_word(r, c);
                wait_valid();
                stall = ((r % N) == c) ? (r % 4) * 60 : 0;
                snap = {res_chan, res_sample, res_ovf, res_mode, 4'h0};
                repeat (stall) @(negedge clk);
                chk(res_valid && snap == {res_chan, res_sample, res_ovf, res_mode, 4'h0},
                    "R9 payload held under back-pressure", {res_chan, res_sample, res_ovf, res_mode, 4'h0}, snap);
                chk(res_chan == 2'(c), "R8 channel order", res_chan, c);
                chk(res_sample == w[31:8], "R6 sample bits", res_sample, w[31:8]);
                chk(res_ovf == w[3], "R7 overflow bit", res_ovf, w[3]);
                chk(res_mode == r[0], "R10 mode captured", res_mode, r[0]);
                accept();
                chk(!res_valid, "R9 valid drops after accept", res_valid, 0);
            end
            while (cs_n != 3'b110) @(negedge clk);
        end
        chk(mosi_rd_bad == 0, "R6 data line low during reads", mosi_rd_bad, 0);
        chk(edge_bad == 0, "R4 data changes only with clock low", edge_bad, 0);
        chk(!overrun, "R11 no overrun for timely drains", overrun, 0);

        // R11: stall past the conversion period
        arm_round = NR + 1;
        wait_valid();
        chk(!overrun, "R11 overrun not yet raised", overrun, 0);
        repeat (LIM + 100) @(negedge clk);
        chk(overrun, "R11 overrun raised after late drain", overrun, 1);
        for (int c = 0; c < N; c++) begin
            wait_valid();
            chk(res_sample == mk_word(NR, c) >> 8, "R6 sample after stall", res_sample, mk_word(NR, c) >> 8);
            accept();
        end
        repeat (20) @(negedge clk);
        chk(overrun, "R11 overrun sticky", overrun, 1);
        finish_run();
    end
endmodule